// File: doc/BRIEF.md
# Trap Condition Evaluator

This block decides whether a conditional trap instruction fires. It takes a first operand, a second operand and a five-bit condition mask. Each mask bit enables one relation between the operands. Some relations compare the operands as signed values and others as unsigned values. A trap is requested when any enabled relation holds.

The second operand comes from one of two places. It is either a full-width register value or a short immediate that the block sign-extends to full width. The decision is available combinationally on `trap_o`, gated by `valid_i`. A build-time parameter can add a register stage. That stage turns each firing evaluation into a one-cycle `trap_pulse_o` that carries a fixed cause code. Exception vectoring, saving of the program counter and privilege checks are handled by the surrounding pipeline.

Top module: `trap_eval`

## Requirements
- R1: Mask bit 4 enables a trap when the first operand is less than the second, both read as two's-complement signed numbers.
- R2: Mask bit 3 enables a trap when the first operand is greater than the second, both read as signed numbers.
- R3: Mask bit 2 enables a trap when the two operands are equal.
- R4: Mask bit 1 enables a trap when the first operand is less than the second, both read as unsigned numbers.
- R5: Mask bit 0 enables a trap when the first operand is greater than the second, both read as unsigned numbers.
- R6: The trap decision is the OR of all enabled relations. A mask of 0 never traps. A mask of 31 traps for every operand pair.
- R7: When `use_imm_i` is 1, the second operand is `imm_i` sign-extended from bit 15 to 32 bits, and `opb_i` has no effect on the result. The same signed and unsigned rules apply.
- R8: `trap_o` is 0 whenever `valid_i` is 0, whatever the mask and operands. Such a cycle produces no `trap_pulse_o` in the following cycle.
- R9: In the registered build, `trap_pulse_o` is 1 in exactly the cycle after each valid evaluation that traps, and 0 otherwise. In a cycle where it is 1, `trap_cause_o` equals the trap cause code 4. In every other cycle `trap_cause_o` is 0.
- R10: A clock edge with `rst_n` low clears `trap_pulse_o` and `trap_cause_o` to 0, even if a trapping evaluation is presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | An instruction is being evaluated this cycle |
| to_mask_i | input | 5 | Condition mask; bit positions as in R1 to R5 |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Register form of the second operand |
| imm_i | input | 16 | Immediate form of the second operand, sign-extended |
| use_imm_i | input | 1 | Selects the immediate as the second operand |
| trap_o | output | 1 | Combinational trap decision |
| trap_pulse_o | output | 1 | One-cycle trap request (registered build) |
| trap_cause_o | output | 3 | Cause code that goes with the trap request |

## Verification
The bench builds the block with its defaults: 32-bit operands, a 16-bit immediate and the registered output stage enabled. With the register stage present, the one-cycle pulse timing can be checked, including back-to-back trapping evaluations and a reset that lands on a trapping cycle. The 16-bit immediate width lets the vectors reach both sign-extension cases, bit 15 clear and bit 15 set. They also reach the case where signed and unsigned orderings disagree at the 32-bit sign bit.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the trap evaluator: the relation flag layout and the
// program-exception cause codes. The relation struct is packed so that its bit
// order matches the condition mask one for one (bit 4 = signed less).
package trap_pkg;

    localparam int TO_W    = 5;
    localparam int CAUSE_W = 3;

    // One flag per relation, in mask bit order (MSB first).
    typedef struct packed {
        logic s_less;
        logic s_more;
        logic same;
        logic u_less;
        logic u_more;
    } rel_flags_t;

    // Program-exception cause codes; the trap cause is distinct from the rest.
    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_FLOAT   = 3'd1,
        CAUSE_ILLEGAL = 3'd2,
        CAUSE_PRIV    = 3'd3,
        CAUSE_TRAP    = 3'd4
    } cause_e;

endpackage

// File: rtl/trap_operand_sel.sv
`timescale 1ns/1ps
// Chooses the second comparison operand: either the register value or the
// immediate sign-extended to the full data width.
// Assumes IMM_W < DATA_W.
module trap_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic [DATA_W-1:0] operand
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    // Replicate the immediate's top bit into the upper bits.
    always_comb begin
        imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
    end

    // Pick the operand source.
    always_comb begin
        operand = use_imm ? imm_ext : reg_val;
    end
endmodule

// File: rtl/trap_rel_cmp.sv
`timescale 1ns/1ps
// Evaluates all five relations between two operands at once: signed less and
// greater, equality, and unsigned less and greater.
// Assumes nothing about the operands; purely combinational.
module trap_rel_cmp
    import trap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output rel_flags_t        flags
);
    localparam int MSB = DATA_W - 1;

    // Signed ordering.
    always_comb begin
        flags.s_less = $signed(lhs) < $signed(rhs);
        flags.s_more = $signed(lhs) > $signed(rhs);
    end

    // Equality.
    always_comb begin
        flags.same = (lhs == rhs);
    end

    // Unsigned ordering.
    always_comb begin
        flags.u_less = lhs < rhs;
        flags.u_more = lhs > rhs;
    end

    // Cross-checks between the independently built comparators.
    always_comb begin : cmp_checks
        p_signed_trichotomy_r2: assert ($countones({flags.s_less, flags.same, flags.s_more}) == 1);
        p_unsigned_trichotomy_r4: assert ($countones({flags.u_less, flags.same, flags.u_more}) == 1);
        if (lhs[MSB] == rhs[MSB]) begin
            p_sign_agree_r1: assert (flags.s_less == flags.u_less && flags.s_more == flags.u_more);
        end else begin
            p_sign_flip_r5: assert (flags.s_less == flags.u_more);
        end
    end
endmodule

// File: rtl/trap_out_stage.sv
`timescale 1ns/1ps
// Output stage for the trap request. With REGISTERED set, each firing cycle
// produces a one-cycle pulse on the next cycle with the trap cause code; the
// register clears on a synchronous active-low reset. With REGISTERED clear,
// the pulse and cause follow the decision combinationally.
module trap_out_stage
    import trap_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    output logic               pulse,
    output logic [CAUSE_W-1:0] cause
);
    generate
        if (REGISTERED) begin : g_reg
            logic               pulse_q;
            logic [CAUSE_W-1:0] cause_q;

            // Capture the decision and its cause for one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pulse_q <= 1'b0;
                    cause_q <= CAUSE_NONE;
                end else begin
                    pulse_q <= fire;
                    cause_q <= fire ? CAUSE_TRAP : CAUSE_NONE;
                end
            end

            assign pulse = pulse_q;
            assign cause = cause_q;
        end else begin : g_comb
            logic unused_ok;

            // Keep the clock and reset pins consumed in this variant.
            assign unused_ok = clk ^ rst_n;
            assign pulse     = fire;
            assign cause     = fire ? CAUSE_TRAP : CAUSE_NONE;
        end
    endgenerate
endmodule

// File: rtl/trap_eval.sv
`timescale 1ns/1ps
// Trap condition evaluator. Compares the first operand with either a register
// or a sign-extended immediate under a five-bit mask and requests a trap when
// any enabled relation holds. The request is presented combinationally and,
// through trap_out_stage, as an optional registered pulse with a cause code.
// Assumes the caller gates valid_i to one cycle per evaluated instruction.
module trap_eval
    import trap_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int IMM_W      = 16,
    parameter bit REGISTERED = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [TO_W-1:0]    to_mask_i,
    input  logic [DATA_W-1:0]  opa_i,
    input  logic [DATA_W-1:0]  opb_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic               use_imm_i,
    output logic               trap_o,
    output logic               trap_pulse_o,
    output logic [CAUSE_W-1:0] trap_cause_o
);
    logic [DATA_W-1:0] rhs;
    rel_flags_t        rel;
    logic [TO_W-1:0]   hits;
    logic              fire;

    trap_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .use_imm (use_imm_i),
        .reg_val (opb_i),
        .imm_val (imm_i),
        .operand (rhs)
    );

    trap_rel_cmp #(.DATA_W(DATA_W)) u_cmp (
        .lhs   (opa_i),
        .rhs   (rhs),
        .flags (rel)
    );

    // Combine enabled relations into one qualified decision.
    always_comb begin
        hits = to_mask_i & rel;
        fire = valid_i & (|hits);
    end

    assign trap_o = fire;

    trap_out_stage #(.REGISTERED(REGISTERED)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .pulse (trap_pulse_o),
        .cause (trap_cause_o)
    );

    // Mask corner cases: the empty mask is silent, the full mask always fires.
    always_comb begin : mask_checks
        if (to_mask_i == '0) begin
            p_empty_mask_quiet_r6: assert (!trap_o);
        end
        if (valid_i && (&to_mask_i)) begin
            p_full_mask_fires_r6: assert (trap_o);
        end
    end

    generate
        if (REGISTERED) begin : g_reg_checks
            p_pulse_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
                trap_pulse_o |-> $past(valid_i));
            p_idle_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(valid_i) |-> !trap_pulse_o);
            p_cause_pairs_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
                trap_pulse_o == (trap_cause_o == CAUSE_TRAP));
            p_reset_clears_r10: assert property (@(posedge clk)
                !$past(rst_n) |-> (!trap_pulse_o && trap_cause_o == CAUSE_NONE));
        end
    endgenerate
endmodule

// File: tb/trap_eval_bench.sv
`timescale 1ns/1ps
module trap_eval_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [4:0]  to_mask_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [15:0] imm_i = '0;
    logic        use_imm_i = 1'b0;
    logic        trap_o;
    logic        trap_pulse_o;
    logic [2:0]  trap_cause_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    trap_eval u_trap_eval (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (valid_i),
        .to_mask_i    (to_mask_i),
        .opa_i        (opa_i),
        .opb_i        (opb_i),
        .imm_i        (imm_i),
        .use_imm_i    (use_imm_i),
        .trap_o       (trap_o),
        .trap_pulse_o (trap_pulse_o),
        .trap_cause_o (trap_cause_o)
    );

    // Vector: {req, mask, use_imm, a, b, imm, expected}
    localparam int NV = 18;
    localparam logic [90:0] VEC [NV] = '{
        {4'd1, 5'b10000, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b1}, // R1 -1 < 1
        {4'd1, 5'b10000, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0000, 1'b0}, // R1
        {4'd2, 5'b01000, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0000, 1'b1}, // R2
        {4'd2, 5'b01000, 1'b0, 32'h8000_0000, 32'h0000_0000, 16'h0000, 1'b0}, // R2
        {4'd3, 5'b00100, 1'b0, 32'h0000_1234, 32'h0000_1234, 16'h0000, 1'b1}, // R3
        {4'd3, 5'b00100, 1'b0, 32'h0000_1234, 32'h0000_1235, 16'h0000, 1'b0}, // R3
        {4'd4, 5'b00010, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0000, 1'b1}, // R4
        {4'd4, 5'b00010, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0}, // R4
        {4'd5, 5'b00001, 1'b0, 32'h8000_0000, 32'h0000_0000, 16'h0000, 1'b1}, // R5
        {4'd5, 5'b00001, 1'b0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 1'b0}, // R5
        {4'd6, 5'b00000, 1'b0, 32'h0000_0000, 32'h0000_0000, 16'h0000, 1'b0}, // R6 empty
        {4'd6, 5'b11111, 1'b0, 32'h0000_0007, 32'h0000_0003, 16'h0000, 1'b1}, // R6 full
        {4'd6, 5'b11011, 1'b0, 32'h0000_0009, 32'h0000_0009, 16'h0000, 1'b0}, // R6
        {4'd6, 5'b00110, 1'b0, 32'h0000_0003, 32'h0000_0003, 16'h0000, 1'b1}, // R6 OR
        {4'd7, 5'b00100, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 16'hFFFF, 1'b1}, // R7
        {4'd7, 5'b00001, 1'b1, 32'h0000_9000, 32'h0000_0000, 16'h8000, 1'b0}, // R7
        {4'd7, 5'b10000, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 16'h7FFF, 1'b1}, // R7
        {4'd7, 5'b00010, 1'b1, 32'h0001_0000, 32'h0000_0000, 16'hFFFF, 1'b1}  // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        // Reset state, R10 and R8
        repeat (3) @(negedge clk);
        chk("R10 pulse after reset", {31'd0, trap_pulse_o}, 32'd0);
        chk("R10 cause after reset", {29'd0, trap_cause_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle trap", {31'd0, trap_o}, 32'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [3:0] req;
            logic       exp;
            string      tag;
            @(negedge clk);
            {req, to_mask_i, use_imm_i, opa_i, opb_i, imm_i, exp} = VEC[i];
            valid_i = 1'b1;
            tag = $sformatf("R%0d vec%0d trap", req, i);
            #1 chk(tag, {31'd0, trap_o}, {31'd0, exp});
            @(negedge clk);
            valid_i = 1'b0;
            tag = $sformatf("R9 vec%0d pulse", i);
            chk(tag, {31'd0, trap_pulse_o}, {31'd0, exp});
            tag = $sformatf("R9 vec%0d cause", i);
            chk(tag, {29'd0, trap_cause_o}, exp ? 32'd4 : 32'd0);
        end

        // R8: full mask with valid low
        @(negedge clk);
        to_mask_i = 5'b11111; use_imm_i = 1'b0; opa_i = 32'd1; opb_i = 32'd2;
        valid_i = 1'b0;
        #1 chk("R8 trap while not valid", {31'd0, trap_o}, 32'd0);
        @(negedge clk);
        chk("R8 no pulse after idle", {31'd0, trap_pulse_o}, 32'd0);

        // R9: hit, hit, miss back to back
        to_mask_i = 5'b00100; opa_i = 32'd5; opb_i = 32'd5; valid_i = 1'b1;
        @(negedge clk);
        chk("R9 first pulse", {31'd0, trap_pulse_o}, 32'd1);
        opb_i = 32'd5;
        @(negedge clk);
        chk("R9 second pulse", {31'd0, trap_pulse_o}, 32'd1);
        chk("R9 second cause", {29'd0, trap_cause_o}, 32'd4);
        opb_i = 32'd6;
        @(negedge clk);
        chk("R9 pulse drops", {31'd0, trap_pulse_o}, 32'd0);
        chk("R9 cause drops", {29'd0, trap_cause_o}, 32'd0);

        // R10: reset on a trapping cycle
        opb_i = 32'd5; rst_n = 1'b0;
        #1 chk("R10 comb trap under reset", {31'd0, trap_o}, 32'd1);
        @(negedge clk);
        chk("R10 pulse held clear", {31'd0, trap_pulse_o}, 32'd0);
        chk("R10 cause held clear", {29'd0, trap_cause_o}, 32'd0);
        valid_i = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        summary();
    end

    // Watchdog
    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end
endmodule